// File: doc/BRIEF.md
# Cell Balancing Switch Controller

This block drives the discharge switches of a twelve-cell series battery-stack monitor. A host writes a configuration word that holds one discharge bit per cell and one bit per general-purpose pin. The block applies those bits exactly as written and never chooses cells on its own. Two safety overrides can pull every discharge switch off: a measurement in progress, and a communication watchdog that has expired.

A registered operating mode selects shutdown, standby or measurement. Shutdown quiets every output and clears the stored configuration. Standby keeps only the host-facing side alive, so writes and GPIO settings still apply but no cell discharges. Measurement mode lets the configured switches conduct, except while a measurement is in flight. The watchdog counts down between communication events. Once it expires, discharge stays blocked until the host writes the configuration again.

Top module: `cell_bal_ctrl`

## Requirements
- R1: In measurement mode, with no measurement busy and no latched expiry, `dis_o[n]` equals stored configuration bit n for every cell (bit 0 is the lowest cell), and no output is ever set where its stored bit is clear.
- R2: A configuration write (`cfg_wr_i` high at a clock edge while the registered mode is not shutdown) stores `cfg_dis_i` and `cfg_gpio_i`, and the stored values reach the outputs after that same edge.
- R3: `mode_i` is registered at each edge with the encoding 00 shutdown, 01 standby, 10 measurement, 11 treated as standby. In standby all `dis_o` are 0, while writes and GPIO control still act.
- R4: `meas_go_i` at an edge while the registered mode is measurement marks a measurement busy, and all `dis_o` are 0 from that edge until an edge with `meas_done_i`. If both strobes arrive at once, the new measurement wins. Leaving measurement mode ends the busy state.
- R5: The watchdog reloads to WDT_CYCLES on `comm_act_i` or on an accepted write. It counts down one per clock otherwise. `wdt_n_o` goes to 0 exactly WDT_CYCLES edges after the last reload, and is 1 at all other times.
- R6: When the watchdog expires, all `dis_o` are cleared. They stay cleared after a `comm_act_i` pulse restores `wdt_n_o`, and return only after an accepted configuration write.
- R7: When `meas_done_i` ends a measurement, `dis_o` returns to the stored configuration, unless the watchdog expired during the measurement. In that case it stays 0.
- R8: A stored GPIO bit of 0 asserts `gpio_pd_o` for that pin (open-drain pull low). A stored GPIO bit of 1 deasserts it, releasing the pin to high impedance so it can be read as an input.
- R9: In shutdown, `dis_o` and `gpio_pd_o` are all 0, `wdt_n_o` is 1, and writes are ignored. The stored configuration is reset to discharge bits 0 and GPIO bits 1 (released), and it stays that way after leaving shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Requested operating mode |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_dis_i | input | N_CELLS | Discharge bits to store, one per cell |
| cfg_gpio_i | input | N_GPIO | GPIO bits to store |
| meas_go_i | input | 1 | Measurement command strobe |
| meas_done_i | input | 1 | Measurement completion strobe |
| comm_act_i | input | 1 | Host communication activity pulse |
| dis_o | output | N_CELLS | Discharge switch enables |
| wdt_n_o | output | 1 | Watchdog status, low when expired |
| gpio_pd_o | output | N_GPIO | Open-drain pull-down enables |

## Verification
The bench builds the block with twelve cells, two GPIO pins and WDT_CYCLES set to 20. With the short timeout, the exact expiry edge can be checked against the last reload. The latched block on discharge can then be exercised on its own, and separately when it overlaps a measurement that is still busy. The cell and pin counts match the real stack, so the discharge patterns cover every switch position.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [1:0] {
    MODE_SHUT = 2'b00,
    MODE_STBY = 2'b01,
    MODE_MEAS = 2'b10,
    MODE_RSVD = 2'b11
  } cbc_mode_e;
endpackage

// File: rtl/cbc_mode_fsm.sv
module cbc_mode_fsm
  import cbc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] mode_i,
  input  logic      meas_go_i,
  input  logic      meas_done_i,
  output cbc_mode_e mode_o,
  output logic      busy_o
);
  cbc_mode_e mode_q, mode_d;
  logic      busy_q, busy_d;

  // next-state: reserved code folds into standby (R3); busy tracks measurement (R4)
  always_comb begin
    mode_d = (mode_i == MODE_RSVD) ? MODE_STBY : cbc_mode_e'(mode_i);
    busy_d = busy_q;
    if (mode_q != MODE_MEAS)  busy_d = 1'b0;
    else if (meas_go_i)       busy_d = 1'b1;
    else if (meas_done_i)     busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SHUT;
      busy_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      busy_q <= busy_d;
    end
  end

  assign mode_o = mode_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/cbc_cfg_reg.sv
module cbc_cfg_reg #(
  parameter int N_CELLS = 12,
  parameter int N_GPIO  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shut_i,
  input  logic               wr_i,
  input  logic [N_CELLS-1:0] dis_i,
  input  logic [N_GPIO-1:0]  gpio_i,
  output logic [N_CELLS-1:0] dis_q_o,
  output logic [N_GPIO-1:0]  gpio_q_o,
  output logic               accept_o
);
  logic [N_CELLS-1:0] dis_q, dis_d;
  logic [N_GPIO-1:0]  gpio_q, gpio_d;
  logic               en;

  assign accept_o = wr_i & ~shut_i;
  assign en       = shut_i | wr_i;

  always_comb begin
    if (shut_i) begin
      dis_d  = '0;
      gpio_d = '1;
    end else begin
      dis_d  = dis_i;
      gpio_d = gpio_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= '0;
      gpio_q <= '1;
    end else if (en) begin
      dis_q  <= dis_d;
      gpio_q <= gpio_d;
    end
  end

  assign dis_q_o  = dis_q;
  assign gpio_q_o = gpio_q;
endmodule

// File: rtl/cbc_wdog.sv
module cbc_wdog #(
  parameter int WDT_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shut_i,
  input  logic reload_i,
  input  logic rearm_i,
  output logic alive_o,
  output logic lat_o
);
  localparam int CNT_W = $clog2(WDT_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WDT_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lat_q, lat_d;
  logic             cnt_en;

  assign cnt_en = shut_i | reload_i | (cnt_q != '0);

  always_comb begin
    if (shut_i || reload_i) cnt_d = RELOAD;
    else                    cnt_d = cnt_q - CNT_W'(1);
  end

  always_comb begin
    lat_d = lat_q;
    if (shut_i)                                   lat_d = 1'b0;
    else if (rearm_i)                             lat_d = 1'b0;
    else if (!reload_i && cnt_q == CNT_W'(1))     lat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RELOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= lat_d;
  end

  assign alive_o = (cnt_q != '0);
  assign lat_o   = lat_q;
endmodule

// File: rtl/cbc_out_gate.sv
module cbc_out_gate #(
  parameter int N_CELLS = 12,
  parameter int N_GPIO  = 2
) (
  input  logic               allow_i,
  input  logic               pins_on_i,
  input  logic [N_CELLS-1:0] dis_q_i,
  input  logic [N_GPIO-1:0]  gpio_q_i,
  output logic [N_CELLS-1:0] dis_o,
  output logic [N_GPIO-1:0]  gpio_pd_o
);
  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    assign dis_o[c] = dis_q_i[c] & allow_i;
  end
  for (genvar g = 0; g < N_GPIO; g++) begin : g_pin
    assign gpio_pd_o[g] = pins_on_i & ~gpio_q_i[g];
  end
endmodule

// File: rtl/cell_bal_ctrl.sv
module cell_bal_ctrl
  import cbc_pkg::*;
#(
  parameter int N_CELLS    = 12,
  parameter int N_GPIO     = 2,
  parameter int WDT_CYCLES = 1000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               cfg_wr_i,
  input  logic [N_CELLS-1:0] cfg_dis_i,
  input  logic [N_GPIO-1:0]  cfg_gpio_i,
  input  logic               meas_go_i,
  input  logic               meas_done_i,
  input  logic               comm_act_i,
  output logic [N_CELLS-1:0] dis_o,
  output logic               wdt_n_o,
  output logic [N_GPIO-1:0]  gpio_pd_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  cbc_mode_e          mode_q;
  logic               meas_busy;
  logic               shut;
  logic               accept;
  logic               wd_alive;
  logic               wd_lat;
  logic               allow;
  logic [N_CELLS-1:0] cfg_dis_q;
  logic [N_GPIO-1:0]  cfg_gpio_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  cbc_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .mode_i      (mode_i),
    .meas_go_i   (meas_go_i),
    .meas_done_i (meas_done_i),
    .mode_o      (mode_q),
    .busy_o      (meas_busy)
  );

  assign shut = (mode_q == MODE_SHUT);

  cbc_cfg_reg #(.N_CELLS(N_CELLS), .N_GPIO(N_GPIO)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .shut_i   (shut),
    .wr_i     (cfg_wr_i),
    .dis_i    (cfg_dis_i),
    .gpio_i   (cfg_gpio_i),
    .dis_q_o  (cfg_dis_q),
    .gpio_q_o (cfg_gpio_q),
    .accept_o (accept)
  );

  cbc_wdog #(.WDT_CYCLES(WDT_CYCLES)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .shut_i   (shut),
    .reload_i (comm_act_i | accept),
    .rearm_i  (accept),
    .alive_o  (wd_alive),
    .lat_o    (wd_lat)
  );

  assign allow   = (mode_q == MODE_MEAS) & ~meas_busy & ~wd_lat;
  assign wdt_n_o = shut | wd_alive;

  cbc_out_gate #(.N_CELLS(N_CELLS), .N_GPIO(N_GPIO)) u_gate (
    .allow_i   (allow),
    .pins_on_i (~shut),
    .dis_q_i   (cfg_dis_q),
    .gpio_q_i  (cfg_gpio_q),
    .dis_o     (dis_o),
    .gpio_pd_o (gpio_pd_o)
  );
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker
  import cbc_pkg::*;
#(
  parameter int N_CELLS = 12,
  parameter int N_GPIO  = 2
) (
  input logic               clk,
  input logic               rst_n_s,
  input cbc_mode_e          mode_q,
  input logic               meas_busy,
  input logic [N_CELLS-1:0] cfg_dis_q,
  input logic [1:0]         mode_i,
  input logic               cfg_wr_i,
  input logic [N_CELLS-1:0] cfg_dis_i,
  input logic [N_GPIO-1:0]  cfg_gpio_i,
  input logic               meas_go_i,
  input logic               comm_act_i,
  input logic [N_CELLS-1:0] dis_o,
  input logic               wdt_n_o,
  input logic [N_GPIO-1:0]  gpio_pd_o
);
  a_r1_dis_within_cfg: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dis_o & ~cfg_dis_q) == '0);

  a_r2_write_reaches_out: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_wr_i && mode_q == MODE_MEAS && mode_i == 2'b10 && !meas_busy && !meas_go_i)
    |=> dis_o == $past(cfg_dis_i));

  a_r4_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n_s)
    meas_busy |-> dis_o == '0);

  a_r5_reload_alive: assert property (@(posedge clk) disable iff (!rst_n_s)
    comm_act_i |=> wdt_n_o);

  a_r6_expired_blocks: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wdt_n_o |-> dis_o == '0);

  a_r8_gpio_follows_write: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_wr_i && mode_q != MODE_SHUT && mode_i != 2'b00)
    |=> gpio_pd_o == ~$past(cfg_gpio_i));

  a_r9_shutdown_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == MODE_SHUT) |-> (dis_o == '0 && gpio_pd_o == '0 && wdt_n_o));
endmodule

bind cell_bal_ctrl cbc_checker #(.N_CELLS(N_CELLS), .N_GPIO(N_GPIO)) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .mode_q     (mode_q),
  .meas_busy  (meas_busy),
  .cfg_dis_q  (cfg_dis_q),
  .mode_i     (mode_i),
  .cfg_wr_i   (cfg_wr_i),
  .cfg_dis_i  (cfg_dis_i),
  .cfg_gpio_i (cfg_gpio_i),
  .meas_go_i  (meas_go_i),
  .comm_act_i (comm_act_i),
  .dis_o      (dis_o),
  .wdt_n_o    (wdt_n_o),
  .gpio_pd_o  (gpio_pd_o)
);

// File: tb/sim_cell_bal_ctrl.sv
module sim_cell_bal_ctrl;
  localparam int N_CELLS = 12;
  localparam int N_GPIO  = 2;
  localparam int WDT     = 20;
  localparam int N_VEC   = 14;

  logic               clk;
  logic               rst_n;
  logic [1:0]         mode_i;
  logic               cfg_wr_i;
  logic [N_CELLS-1:0] cfg_dis_i;
  logic [N_GPIO-1:0]  cfg_gpio_i;
  logic               meas_go_i;
  logic               meas_done_i;
  logic               comm_act_i;
  logic [N_CELLS-1:0] dis_o;
  logic               wdt_n_o;
  logic [N_GPIO-1:0]  gpio_pd_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  cell_bal_ctrl #(.N_CELLS(N_CELLS), .N_GPIO(N_GPIO), .WDT_CYCLES(WDT)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cfg_wr_i(cfg_wr_i),
    .cfg_dis_i(cfg_dis_i), .cfg_gpio_i(cfg_gpio_i), .meas_go_i(meas_go_i),
    .meas_done_i(meas_done_i), .comm_act_i(comm_act_i), .dis_o(dis_o),
    .wdt_n_o(wdt_n_o), .gpio_pd_o(gpio_pd_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // fields: mode, wr, dis, gpio, go, done | exp dis, exp pd, exp wdt_n
  localparam logic [33:0] VEC [N_VEC] = '{
    {2'd0, 1'b1, 12'hFFF, 2'b00, 1'b0, 1'b0, 12'h000, 2'b00, 1'b1}, // R9 write ignored
    {2'd1, 1'b0, 12'h000, 2'b00, 1'b0, 1'b0, 12'h000, 2'b00, 1'b1}, // R9 cfg still reset
    {2'd1, 1'b1, 12'h0A5, 2'b10, 1'b0, 1'b0, 12'h000, 2'b01, 1'b1}, // R3 standby, R8
    {2'd2, 1'b0, 12'h000, 2'b00, 1'b0, 1'b0, 12'h0A5, 2'b01, 1'b1}, // R1
    {2'd2, 1'b0, 12'h000, 2'b00, 1'b1, 1'b0, 12'h000, 2'b01, 1'b1}, // R4 busy
    {2'd2, 1'b1, 12'hF0F, 2'b01, 1'b0, 1'b0, 12'h000, 2'b10, 1'b1}, // R2 write while busy
    {2'd2, 1'b0, 12'h000, 2'b00, 1'b0, 1'b1, 12'hF0F, 2'b10, 1'b1}, // R7 return
    {2'd2, 1'b0, 12'h000, 2'b00, 1'b1, 1'b1, 12'h000, 2'b10, 1'b1}, // R4 go wins
    {2'd2, 1'b0, 12'h000, 2'b00, 1'b0, 1'b1, 12'hF0F, 2'b10, 1'b1}, // R7
    {2'd1, 1'b0, 12'h000, 2'b00, 1'b0, 1'b0, 12'h000, 2'b10, 1'b1}, // R3
    {2'd2, 1'b0, 12'h000, 2'b00, 1'b0, 1'b0, 12'hF0F, 2'b10, 1'b1}, // R1
    {2'd0, 1'b0, 12'h000, 2'b00, 1'b0, 1'b0, 12'h000, 2'b00, 1'b1}, // R9 quiet
    {2'd1, 1'b0, 12'h000, 2'b00, 1'b0, 1'b0, 12'h000, 2'b00, 1'b1}, // R9 cleared
    {2'd2, 1'b0, 12'h000, 2'b00, 1'b0, 1'b0, 12'h000, 2'b00, 1'b1}  // R9 cleared
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_all(input string req, input logic [11:0] ed,
                         input logic [1:0] ep, input logic ew);
    check({req, " dis"}, 32'(dis_o), 32'(ed));
    check({req, " gpio"}, 32'(gpio_pd_o), 32'(ep));
    check({req, " wdt"}, 32'(wdt_n_o), 32'(ew));
  endtask

  initial begin
    rst_n = 1'b0; mode_i = 2'd0; cfg_wr_i = 1'b0; cfg_dis_i = '0;
    cfg_gpio_i = '1; meas_go_i = 1'b0; meas_done_i = 1'b0; comm_act_i = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R9 reset", 12'h000, 2'b00, 1'b1);
    rst_n = 1'b1;
    repeat (3) tick();
    chk_all("R9 after reset", 12'h000, 2'b00, 1'b1);

    for (int i = 0; i < N_VEC; i++) begin
      mode_i      = VEC[i][33:32];
      cfg_wr_i    = VEC[i][31];
      cfg_dis_i   = VEC[i][30:19];
      cfg_gpio_i  = VEC[i][18:17];
      meas_go_i   = VEC[i][16];
      meas_done_i = VEC[i][15];
      comm_act_i  = 1'b1;
      tick();
      chk_all($sformatf("vec%0d R1/R2/R3/R4/R7/R8/R9", i),
              VEC[i][14:3], VEC[i][2:1], VEC[i][0]);
    end

    // watchdog expiry: R5, R6
    mode_i = 2'd2; meas_go_i = 0; meas_done_i = 0; comm_act_i = 0;
    cfg_wr_i = 1; cfg_dis_i = 12'h3C3; cfg_gpio_i = 2'b11;
    tick();
    cfg_wr_i = 0;
    check("R1 3C3", 32'(dis_o), 32'h3C3);
    for (int i = 1; i <= WDT; i++) begin
      tick();
      if (i == WDT - 1) begin
        check("R5 alive before timeout", 32'(wdt_n_o), 32'd1);
        check("R5 dis before timeout", 32'(dis_o), 32'h3C3);
      end
    end
    check("R5 expired at timeout", 32'(wdt_n_o), 32'd0);
    check("R6 dis cleared on expiry", 32'(dis_o), 32'h000);
    tick();
    check("R5 stays expired", 32'(wdt_n_o), 32'd0);
    comm_act_i = 1; tick(); comm_act_i = 0;
    check("R6 activity revives status", 32'(wdt_n_o), 32'd1);
    check("R6 dis still blocked", 32'(dis_o), 32'h000);
    tick();
    check("R6 dis still blocked later", 32'(dis_o), 32'h000);
    cfg_wr_i = 1; tick(); cfg_wr_i = 0;
    check("R6 write rearms", 32'(dis_o), 32'h3C3);

    // expiry during measurement: R7
    meas_go_i = 1; tick(); meas_go_i = 0;
    check("R4 busy", 32'(dis_o), 32'h000);
    repeat (WDT - 2) tick();
    check("R5 alive one before", 32'(wdt_n_o), 32'd1);
    tick();
    check("R5 expired in measurement", 32'(wdt_n_o), 32'd0);
    meas_done_i = 1; tick(); meas_done_i = 0;
    check("R7 stays off after expiry", 32'(dis_o), 32'h000);
    cfg_wr_i = 1; comm_act_i = 1; tick(); cfg_wr_i = 0;
    check("R7 restored by write", 32'(dis_o), 32'h3C3);

    // reserved mode acts as standby: R3, R8
    mode_i = 2'd3; tick();
    check("R3 reserved no discharge", 32'(dis_o), 32'h000);
    check("R8 pins released", 32'(gpio_pd_o), 32'h0);
    cfg_wr_i = 1; cfg_gpio_i = 2'b00; tick(); cfg_wr_i = 0;
    check("R8 both pulled low", 32'(gpio_pd_o), 32'h3);
    mode_i = 2'd2; tick();
    check("R3 back to measurement", 32'(dis_o), 32'h3C3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule